// File: doc/BRIEF.md
# Shutdown Controller with Debounced Wake-up Inputs

This block sits in the always-on domain and runs from the 32.768 kHz slow clock. It owns a single main-power-enable output. Software stops the chip by writing a key-protected command word. While power is off, the block watches a set of wake pins and two timer alarm lines. Each wake pin has its own enable and its own active level. After a two-flop synchronizer, each pin passes through a debouncer whose length comes from a small non-linear table of slow-clock counts.

When an enabled source qualifies while power is off, the block raises the power enable again. It then logs which sources caused the wake in a status word. That word clears when it is read, and it reads zero after a plain power-on. Registers sit on a simple 32-bit bus at word offsets 0x0 (command), 0x4 (mode), 0x8 (wake status) and 0xC (pin configuration). Only byte-address bits 3:2 are decoded.

Top module: `shutdown_wake_ctl`

## Requirements
- R1: After reset, `pwr_en` is 1 and all four registers read 0. The status word reads 0 until a wake event occurs.
- R2: A bus write to offset 0x0 with bit 0 set and bits 31:24 equal to 0xA5 drives `pwr_en` low from the next clock edge.
- R3: A write to offset 0x0 with any other key, or with bit 0 clear, leaves `pwr_en` unchanged. The command register always reads 0.
- R4: Mode (0x4) keeps only bits 26:24, 17 and 16, and reads the other bits as 0. Pin configuration (0xC) reads back as written. Writes to status (0x8) are ignored.
- R5: Configuration bit i enables wake pin i. Bit 16+i selects its active level: 1 means active-high, 0 means active-low. A pin whose enable is 0 never causes a wake.
- R6: Mode bits 26:24 pick the debounce length N. Codes 0 to 5 give 0, 3, 32, 512, 4096 and 32768 cycles, and codes 6 and 7 behave like code 5. A pin that turns active and stays active raises `pwr_en` exactly N+3 clock edges after the change: two synchronizer stages, N counted cycles and one capture edge.
- R7: If the synchronized pin leaves its active level for even one cycle, its debounce count restarts from zero.
- R8: Mode bit 17 enables wake from `rtc_alarm`, and mode bit 16 enables wake from `rtt_alarm`. An alarm is sampled directly, so it wakes on the first edge it is high. A disabled alarm has no effect.
- R9: While `pwr_en` is 0, any qualified enabled source sets `pwr_en` to 1 at that edge. The same edge ORs the causes into status: bit 16+i for pin i, bit 5 for the RTC alarm and bit 4 for the RTT alarm.
- R10: A read of status returns the current value, and the edge that ends the read clears it. A cause captured on that same edge is kept.
- R11: With mode and configuration both zero, no input can raise `pwr_en` once it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Bus access strobe, one cycle per access |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Byte-address bits 3:2 (register select) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| wake_pin | input | NPIN | Asynchronous wake pins |
| rtc_alarm | input | 1 | Calendar alarm, synchronous to clk |
| rtt_alarm | input | 1 | Interval timer alarm, synchronous to clk |
| pwr_en | output | 1 | Main power enable |

## Verification
Two functions can fall in the same cycle: software reading status, which clears it, and a wake capture, which sets cause bits. The bench holds a status read active across the wake edge of a zero-length-debounce pin. It checks that the read returns the old value and that the new cause survives the clear. A behavioural model, compared every cycle, also judges the case where the debounce count restarts on a one-cycle glitch just before qualification.

// File: rtl/shutdown_wake_ctl.sv
module shutdown_wake_ctl #(
  parameter int NPIN = 16,
  parameter int CNT_W = 16,
  parameter logic [7:0] KEY = 8'hA5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_en,
  input  logic            reg_wr,
  input  logic [3:2]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [NPIN-1:0] wake_pin,
  input  logic            rtc_alarm,
  input  logic            rtt_alarm,
  output logic            pwr_en
);

  localparam logic [31:0] PIN_MASK = (32'h1 << NPIN) - 32'h1;
  localparam logic [31:0] CFG_MASK = PIN_MASK | (PIN_MASK << 16);

  logic [2:0]      dbc_sel;
  logic            rtc_en, rtt_en;
  logic [31:0]     cfg_q, status;
  logic [NPIN-1:0] sy1, sy2, act, qual;
  logic [CNT_W-1:0] lim;
  logic [31:0]     cause;
  logic            cmd_ok, cmd_bad, rd_stat, wake;

  assign cmd_ok  = reg_en & reg_wr & (reg_addr == 2'd0) & reg_wdata[0] & (reg_wdata[31:24] == KEY);
  assign cmd_bad = reg_en & reg_wr & (reg_addr == 2'd0) & ~cmd_ok;
  assign rd_stat = reg_en & ~reg_wr & (reg_addr == 2'd2);

  always_comb begin
    case (dbc_sel)
      3'd0:    lim = CNT_W'(0);
      3'd1:    lim = CNT_W'(3);
      3'd2:    lim = CNT_W'(32);
      3'd3:    lim = CNT_W'(512);
      3'd4:    lim = CNT_W'(4096);
      default: lim = CNT_W'(32768);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= wake_pin;
      sy2 <= sy1;
    end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [CNT_W-1:0] cnt;
    assign act[i]  = cfg_q[i] & (sy2[i] == cfg_q[16+i]);
    assign qual[i] = act[i] & (cnt >= lim);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        cnt <= '0;
      else if (!act[i])  cnt <= '0;
      else if (cnt < lim) cnt <= cnt + CNT_W'(1);
  end

  always_comb begin
    cause = '0;
    cause[16 +: NPIN] = qual;
    cause[5] = rtc_en & rtc_alarm;
    cause[4] = rtt_en & rtt_alarm;
  end

  assign wake = ~pwr_en & (|cause);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pwr_en  <= 1'b1;
      status  <= '0;
      dbc_sel <= '0;
      rtc_en  <= 1'b0;
      rtt_en  <= 1'b0;
      cfg_q   <= '0;
    end else begin
      if (wake)        pwr_en <= 1'b1;
      else if (cmd_ok) pwr_en <= 1'b0;
      status <= (rd_stat ? 32'h0 : status) | (wake ? cause : 32'h0);
      if (reg_en && reg_wr && reg_addr == 2'd1) begin
        dbc_sel <= reg_wdata[26:24];
        rtc_en  <= reg_wdata[17];
        rtt_en  <= reg_wdata[16];
      end
      if (reg_en && reg_wr && reg_addr == 2'd3)
        cfg_q <= reg_wdata & CFG_MASK;
    end

  always_comb
    case (reg_addr)
      2'd1:    reg_rdata = {5'b0, dbc_sel, 6'b0, rtc_en, rtt_en, 16'b0};
      2'd2:    reg_rdata = status;
      2'd3:    reg_rdata = cfg_q;
      default: reg_rdata = '0;
    endcase

  assert_shutdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && pwr_en) |=> !pwr_en);

  assert_badcmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_bad && pwr_en) |=> pwr_en);

  assert_wake_logged_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> (status != 32'h0));

  assert_rdclear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !wake) |=> (status == 32'h0));

  assert_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[NPIN-1:0] == '0 && !rtc_en && !rtt_en && !pwr_en) |=> !pwr_en);

endmodule

// File: tb/sim_shutdown_wake_ctl.sv
`timescale 1ns/1ps
module sim_shutdown_wake_ctl;
  logic clk = 0, rst_n = 0;
  logic reg_en = 0, reg_wr = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [15:0] pins = 0;
  logic rtc = 0, rtt = 0, pwr_en;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  shutdown_wake_ctl u0 (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_addr(addr[3:2]), .reg_wdata(wdata), .reg_rdata(rdata),
    .wake_pin(pins), .rtc_alarm(rtc), .rtt_alarm(rtt), .pwr_en(pwr_en));

  // behavioural reference
  bit m_pwr;
  logic [31:0] m_mode, m_cfg, m_stat;
  logic [15:0] m_s1, m_s2;
  int m_cnt[16];

  function automatic int dbc_len(input logic [2:0] c);
    int t[6] = '{0, 3, 32, 512, 4096, 32768};
    return (c > 5) ? t[5] : t[c];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pwr = 1; m_mode = 0; m_cfg = 0; m_stat = 0; m_s1 = 0; m_s2 = 0;
      for (int i = 0; i < 16; i++) m_cnt[i] = 0;
    end else begin
      int lim;
      logic [31:0] cause;
      bit act, wk;
      lim = dbc_len(m_mode[26:24]);
      cause = 0;
      for (int i = 0; i < 16; i++) begin
        act = m_cfg[i] && (m_s2[i] == m_cfg[16+i]);
        if (act && m_cnt[i] >= lim) cause[16+i] = 1;
        if (!act) m_cnt[i] = 0;
        else if (m_cnt[i] < lim) m_cnt[i]++;
      end
      cause[5] = m_mode[17] && rtc;
      cause[4] = m_mode[16] && rtt;
      wk = !m_pwr && cause != 0;
      if (reg_en && !reg_wr && addr == 4'h8) m_stat = 0;
      if (wk) m_stat |= cause;
      if (wk) m_pwr = 1;
      else if (reg_en && reg_wr && addr == 4'h0 && wdata[0] && wdata[31:24] == 8'hA5) m_pwr = 0;
      if (reg_en && reg_wr && addr == 4'h4) m_mode = wdata & 32'h0703_0000;
      if (reg_en && reg_wr && addr == 4'hC) m_cfg = wdata;
      m_s2 = m_s1;
      m_s1 = pins;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always begin
    logic [31:0] er;
    @(negedge clk);
    #1;
    if (rst_n) begin
      case (addr[3:2])
        2'd1: er = m_mode;
        2'd2: er = m_stat;
        2'd3: er = m_cfg;
        default: er = 0;
      endcase
      chk(pwr_en === m_pwr, "R2 R9 pwr_en vs model", 32'(pwr_en), 32'(m_pwr));
      chk(rdata === er, "R4 R10 rdata vs model", rdata, er);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_en = 1; reg_wr = 1; addr = a; wdata = d;
    @(negedge clk); reg_en = 0; reg_wr = 0; wdata = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_en = 1; reg_wr = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); reg_en = 0; addr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_wake(input int maxc, output int n);
    n = 0;
    while (n < maxc) begin
      @(negedge clk); n++;
      #1;
      if (pwr_en) break;
    end
  endtask

  task automatic shut();
    wr(4'h0, 32'hA500_0001);
    idle(2);
    chk(pwr_en == 0, "R2 shutdown", 32'(pwr_en), 0);
  endtask

  task automatic latency(input logic [2:0] code);
    logic [31:0] d;
    int n, exp;
    exp = dbc_len(code) + 3;
    pins = 0;
    wr(4'h4, {5'b0, code, 24'b0});
    wr(4'hC, 32'h0008_0008);
    idle(3);
    shut();
    @(negedge clk); pins[3] = 1;
    wait_wake(40000, n);
    chk(n == exp, "R6 debounce latency", 32'(n), 32'(exp));
    rd(4'h8, d);
    chk(d == 32'h0008_0000, "R9 pin cause", d, 32'h0008_0000);
    pins[3] = 0;
    idle(4);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    idle(5);
    rst_n = 1;
    idle(2);
    // R1
    chk(pwr_en == 1, "R1 pwr_en after reset", 32'(pwr_en), 1);
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4), d);
      chk(d == 0, "R1 register after reset", d, 0);
    end
    // R4
    wr(4'h4, 32'hFFFF_FFFF); rd(4'h4, d);
    chk(d == 32'h0703_0000, "R4 mode readback", d, 32'h0703_0000);
    wr(4'hC, 32'h1234_5678); rd(4'hC, d);
    chk(d == 32'h1234_5678, "R4 cfg readback", d, 32'h1234_5678);
    wr(4'h8, 32'hFFFF_FFFF); rd(4'h8, d);
    chk(d == 0, "R4 status not writable", d, 0);
    wr(4'h4, 0); wr(4'hC, 0);
    // R3
    wr(4'h0, 32'h5A00_0001); idle(2);
    chk(pwr_en == 1, "R3 wrong key", 32'(pwr_en), 1);
    wr(4'h0, 32'hA500_0000); idle(2);
    chk(pwr_en == 1, "R3 bit0 clear", 32'(pwr_en), 1);
    rd(4'h0, d);
    chk(d == 0, "R3 command reads zero", d, 0);
    // R6 lengths
    latency(3'd0);
    latency(3'd1);
    latency(3'd3);
    latency(3'd7);
    // R7 glitch restart, code 2
    wr(4'h4, 32'h0200_0000); wr(4'hC, 32'h0008_0008); idle(3);
    shut();
    @(negedge clk); pins[3] = 1;
    idle(20); pins[3] = 0;
    idle(1); pins[3] = 1;
    idle(20);
    chk(pwr_en == 0, "R7 no wake right after glitch", 32'(pwr_en), 0);
    wait_wake(200, n);
    chk(n == 15, "R7 count restarted", 32'(n), 15);
    rd(4'h8, d);
    pins[3] = 0; idle(4);
    // R5 active-low pin 7, disabled pin 5
    pins = 16'h0080;
    wr(4'h4, 32'h0100_0000); wr(4'hC, 32'h0000_0080); idle(3);
    shut();
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); pins[5] = ~pins[5];
    end
    idle(10);
    chk(pwr_en == 0, "R5 disabled pin ignored", 32'(pwr_en), 0);
    @(negedge clk); pins[7] = 0;
    wait_wake(100, n);
    chk(n == 6, "R5 active-low wake", 32'(n), 6);
    rd(4'h8, d);
    chk(d == 32'h0080_0000, "R5 active-low cause", d, 32'h0080_0000);
    pins = 0; idle(4);
    // R8 alarms
    wr(4'hC, 0); wr(4'h4, 32'h0002_0000); idle(2);
    shut();
    @(negedge clk); rtt = 1;
    @(negedge clk); rtt = 0;
    idle(3);
    chk(pwr_en == 0, "R8 disabled rtt ignored", 32'(pwr_en), 0);
    @(negedge clk); rtc = 1;
    wait_wake(10, n); rtc = 0;
    chk(n == 1, "R8 rtc wake", 32'(n), 1);
    rd(4'h8, d);
    chk(d == 32'h20, "R9 rtc cause", d, 32'h20);
    wr(4'h4, 32'h0001_0000); idle(2);
    shut();
    @(negedge clk); rtt = 1;
    wait_wake(10, n); rtt = 0;
    chk(n == 1, "R8 rtt wake", 32'(n), 1);
    rd(4'h8, d);
    chk(d == 32'h10, "R9 rtt cause", d, 32'h10);
    // R10 read and capture on the same edge
    wr(4'h4, 0); wr(4'hC, 32'h0008_0008); idle(3);
    shut();
    @(negedge clk); pins[3] = 1; reg_en = 1; reg_wr = 0; addr = 4'h8;
    wait_wake(20, n);
    chk(rdata == 32'h0008_0000, "R10 cause kept on clearing edge", rdata, 32'h0008_0000);
    @(negedge clk); #1;
    chk(rdata == 0, "R10 cleared by read", rdata, 0);
    @(negedge clk); reg_en = 0; addr = 0; pins = 0;
    idle(4);
    // R11
    wr(4'h4, 0); wr(4'hC, 0); idle(2);
    shut();
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); pins = ~pins; rtc = ~rtc; rtt = ~rtt;
    end
    idle(5);
    chk(pwr_en == 0, "R11 all sources disabled", 32'(pwr_en), 0);
    rtc = 0; rtt = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule